// File: doc/BRIEF.md
# Scratchpad EEPROM Command Engine

This block is the byte-level memory command engine of a single-wire slave memory device. A bit-timing layer in front of it delivers whole received bytes, flags a received byte that ended early, and asks for the next byte to transmit. The engine holds a 32-byte volatile staging buffer, a target-address register and an end/status register. It drives a 512-byte nonvolatile array, modelled here as internal storage.

Data reaches the array in two steps. A write-buffer command stages bytes at a target offset. A read-buffer command lets the host verify those bytes. A commit command then echoes the address and end/status bytes as an authorization and moves the staged bytes into the array during a fixed busy interval. A read-array command streams the array out, and as it goes it refills the staging buffer. A bus-reset input aborts the current command. A power-loss input marks the staged data as invalid.

Top module: `spad_mem_ctrl`

## Requirements
- R1: Command 0Fh takes the low target-address byte, then the high one, then data bytes. Each data byte is stored at the buffer offset that starts at T[4:0] and advances by one per further full byte. The end/status byte is {AA (bit 7), 0 (bit 6), PF (bit 5), E[4:0]}, where E is the offset of the last full byte written.
- R2: As the target address is captured, bits 15:9 are forced to zero, so the high address byte reads back as 00h or 01h.
- R3: An incomplete final byte (rxPartial during data) is discarded and sets PF. Command 0Fh clears PF and AA. A pulse on powerLoss sets PF.
- R4: When a write stores a byte at offset 31, the engine returns the inverted CRC-16 (reflected polynomial A001h, start value 0). The CRC covers the command byte, both address bytes as sent and all data bytes. The low byte comes first, and every later byte reads FFh.
- R5: Command AAh returns the low address byte, the high address byte, the end/status byte, then buffer bytes from offset T[4:0] through 31. Every byte after that reads FFh.
- R6: Command 55h followed by three bytes equal to the low address byte, the high address byte and the end/status byte, with PF clear, sets AA. It then copies buffer offsets T[4:0] through E into the array at the target page. On any mismatch, or with PF set, nothing is written and every byte reads FFh.
- R7: After an accepted authorization, busy is high for PROG_CYCLES cycles and received bytes are ignored. After that, every byte reads AAh (bits 0,1,0,1,... least significant bit first) until a bus reset.
- R8: Command F0h takes two address bytes, masked as in R2, that replace the target address but leave E unchanged. It streams array bytes from that address up to 1FFh, then reads FFh.
- R9: Each byte that F0h delivers is also written into the buffer at offset address[4:0].
- R10: busReset aborts any command and returns the engine to waiting for a command byte. Buffer contents, the target address and end/status are kept.
- R11: An unrecognized command byte leaves the engine returning FFh and ignoring received bytes until a bus reset.
- R12: After rst_n the target address is 0000h, end/status is 20h (PF set), busy is low and txData is FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | Bus reset seen by the bit layer; aborts the command |
| powerLoss | input | 1 | Pulse marking the staged data as invalid |
| rxValid | input | 1 | One-cycle strobe: rxData holds a complete received byte |
| rxData | input | 8 | Received byte |
| rxPartial | input | 1 | One-cycle strobe: a received byte ended before 8 bits |
| txReq | input | 1 | One-cycle strobe: txData is taken and the next byte is wanted |
| txData | output | 8 | Byte offered for transmission |
| busy | output | 1 | High during the array programming interval |

## Verification
The write path is tried with three patterns: a short write in mid-buffer, a write that ends exactly at offset 31 from an out-of-range address, and a write cut short by a partial byte. Together these separate the end-offset arithmetic, the address masking, the CRC trigger at the buffer end and the setting of PF. The commit command is given a correct echo, an echo with one wrong status byte, and a correct echo while PF is set. Only the first may program the array, which a later read-array confirms. Read-array is started both mid-array and near the array end, and a later read-buffer shows that the buffer was refilled and the target address replaced.

// File: rtl/spadmem_pkg.sv
package spadmem_pkg;
  localparam int OFF_W = 5;
  localparam int SPAD_BYTES = 1 << OFF_W;

  localparam logic [7:0] CMD_WRITE_BUF = 8'h0F;
  localparam logic [7:0] CMD_READ_BUF  = 8'hAA;
  localparam logic [7:0] CMD_COMMIT    = 8'h55;
  localparam logic [7:0] CMD_READ_ARR  = 8'hF0;

  typedef enum logic [3:0] {
    TX_ONES, TX_TA1, TX_TA2, TX_ES, TX_SPAD, TX_CRCL, TX_CRCH, TX_MEM, TX_ALT
  } txsel_e;

  typedef struct packed {
    logic clrFlags;
    logic crcInit;
    logic crcFeed;
    logic taLo;
    logic taHi;
    logic setE;
    logic wrData;
    logic setPf;
    logic rsStart;
    logic rsStep;
    logic memStart;
    logic rmStep;
    logic copyStart;
    logic abort;
    logic busy;
    txsel_e txSel;
  } strobe_t;

  typedef struct packed {
    logic [7:0] ta1Byte;
    logic [7:0] ta2Byte;
    logic [7:0] esByte;
    logic       pf;
    logic       wrAtEnd;
  } status_t;
endpackage

// File: rtl/spadmem_ctrl.sv
module spadmem_ctrl
  import spadmem_pkg::*;
#(
  parameter int PROG_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busReset,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       rxPartial,
  input  logic       txReq,
  input  status_t    st,
  output strobe_t    stb
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  typedef enum logic [4:0] {
    ST_IDLE, ST_WS_A1, ST_WS_A2, ST_WS_DAT, ST_WS_CRC0, ST_WS_CRC1,
    ST_RS_A1, ST_RS_A2, ST_RS_ES, ST_RS_DAT,
    ST_CP_A1, ST_CP_A2, ST_CP_ES, ST_CP_PROG, ST_CP_OK,
    ST_RM_A1, ST_RM_A2, ST_RM_DAT, ST_SINK
  } state_e;

  state_e state, nextState;
  logic [CNT_W-1:0] progCnt;
  logic authOk;

  always_comb begin
    stb = '0;
    stb.txSel = TX_ONES;
    nextState = state;
    unique case (state)
      ST_IDLE: if (rxValid) begin
        unique case (rxData)
          CMD_WRITE_BUF: begin stb.clrFlags = 1'b1; stb.crcInit = 1'b1; nextState = ST_WS_A1; end
          CMD_READ_BUF:  begin stb.rsStart = 1'b1; nextState = ST_RS_A1; end
          CMD_COMMIT:    nextState = ST_CP_A1;
          CMD_READ_ARR:  nextState = ST_RM_A1;
          default:       nextState = ST_SINK;
        endcase
      end
      ST_WS_A1: if (rxValid) begin
        stb.taLo = 1'b1; stb.setE = 1'b1; stb.crcFeed = 1'b1; nextState = ST_WS_A2;
      end
      ST_WS_A2: if (rxValid) begin
        stb.taHi = 1'b1; stb.crcFeed = 1'b1; nextState = ST_WS_DAT;
      end
      ST_WS_DAT: begin
        if (rxPartial) begin
          stb.setPf = 1'b1; nextState = ST_SINK;
        end else if (rxValid) begin
          stb.wrData = 1'b1; stb.crcFeed = 1'b1;
          if (st.wrAtEnd) nextState = ST_WS_CRC0;
        end
      end
      ST_WS_CRC0: begin stb.txSel = TX_CRCL; if (txReq) nextState = ST_WS_CRC1; end
      ST_WS_CRC1: begin stb.txSel = TX_CRCH; if (txReq) nextState = ST_SINK; end
      ST_RS_A1: begin stb.txSel = TX_TA1; if (txReq) nextState = ST_RS_A2; end
      ST_RS_A2: begin stb.txSel = TX_TA2; if (txReq) nextState = ST_RS_ES; end
      ST_RS_ES: begin stb.txSel = TX_ES; if (txReq) nextState = ST_RS_DAT; end
      ST_RS_DAT: begin stb.txSel = TX_SPAD; stb.rsStep = txReq; end
      ST_CP_A1: if (rxValid) nextState = ST_CP_A2;
      ST_CP_A2: if (rxValid) nextState = ST_CP_ES;
      ST_CP_ES: if (rxValid) begin
        if (authOk && rxData == st.esByte && !st.pf) begin
          stb.copyStart = 1'b1; nextState = ST_CP_PROG;
        end else begin
          nextState = ST_SINK;
        end
      end
      ST_CP_PROG: begin
        stb.busy = 1'b1;
        if (progCnt == CNT_W'(PROG_CYCLES - 1)) nextState = ST_CP_OK;
      end
      ST_CP_OK: stb.txSel = TX_ALT;
      ST_RM_A1: if (rxValid) begin stb.taLo = 1'b1; nextState = ST_RM_A2; end
      ST_RM_A2: if (rxValid) begin stb.taHi = 1'b1; stb.memStart = 1'b1; nextState = ST_RM_DAT; end
      ST_RM_DAT: begin stb.txSel = TX_MEM; stb.rmStep = txReq; end
      default: stb.txSel = TX_ONES;
    endcase
    if (busReset) begin
      stb = '0;
      stb.txSel = TX_ONES;
      stb.abort = 1'b1;
      nextState = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      progCnt <= '0;
      authOk <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.copyStart) progCnt <= '0;
      else if (state == ST_CP_PROG) progCnt <= progCnt + 1'b1;
      if (state == ST_CP_A1 && rxValid) authOk <= (rxData == st.ta1Byte);
      else if (state == ST_CP_A2 && rxValid) authOk <= authOk && (rxData == st.ta2Byte);
    end
  end

  // R10: a bus reset always brings the engine back to command wait
  assert_abort_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busReset |=> (state == ST_IDLE && !stb.busy));

  // R6: a commit is only accepted out of the status-byte step
  assert_commit_after_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb.busy) |-> $past(state == ST_CP_ES && rxValid));
endmodule

// File: rtl/spadmem_dpath.sv
module spadmem_dpath
  import spadmem_pkg::*;
#(
  parameter int PAGES = 16  // 16..2048 pages of 32 bytes
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       powerLoss,
  input  logic [7:0] rxData,
  input  strobe_t    stb,
  output status_t    st,
  output logic [7:0] txData
);
  localparam int PAGE_W = $clog2(PAGES);
  localparam int ADDR_W = OFF_W + PAGE_W;
  localparam int MEM_BYTES = PAGES * SPAD_BYTES;
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] ta;
  logic [OFF_W-1:0]  eOff, wrIdx, cpPtr;
  logic              first, pf, aa, copyActive;
  logic [15:0]       crc;
  logic [OFF_W:0]    rdPtr;
  logic [ADDR_W:0]   memPtr;
  logic [7:0]        spad [SPAD_BYTES];
  logic [7:0]        mem  [MEM_BYTES];

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  assign wrIdx = first ? eOff : eOff + 1'b1;
  assign st.ta1Byte = ta[7:0];
  assign st.ta2Byte = 8'(ta[ADDR_W-1:8]);
  assign st.esByte = {aa, 1'b0, pf, eOff};
  assign st.pf = pf;
  assign st.wrAtEnd = &wrIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta <= '0; eOff <= '0; first <= 1'b0; pf <= 1'b1; aa <= 1'b0;
      crc <= '0; rdPtr <= '0; memPtr <= '0; cpPtr <= '0; copyActive <= 1'b0;
    end else begin
      if (stb.taLo) ta[7:0] <= rxData;
      if (stb.taHi) ta[ADDR_W-1:8] <= rxData[HI_W-1:0];
      if (stb.setE) begin eOff <= rxData[OFF_W-1:0]; first <= 1'b1; end
      else if (stb.wrData) begin eOff <= wrIdx; first <= 1'b0; end
      if (powerLoss || stb.setPf) pf <= 1'b1;
      else if (stb.clrFlags) pf <= 1'b0;
      if (stb.clrFlags) aa <= 1'b0;
      else if (stb.copyStart) aa <= 1'b1;
      if (stb.crcInit) crc <= crcStep(16'h0000, rxData);
      else if (stb.crcFeed) crc <= crcStep(crc, rxData);
      if (stb.rsStart) rdPtr <= {1'b0, ta[OFF_W-1:0]};
      else if (stb.rsStep && !rdPtr[OFF_W]) rdPtr <= rdPtr + 1'b1;
      if (stb.memStart) memPtr <= {1'b0, rxData[HI_W-1:0], ta[7:0]};
      else if (stb.rmStep && !memPtr[ADDR_W]) memPtr <= memPtr + 1'b1;
      if (stb.abort) copyActive <= 1'b0;
      else if (stb.copyStart) begin copyActive <= 1'b1; cpPtr <= ta[OFF_W-1:0]; end
      else if (copyActive) begin
        if (cpPtr == eOff) copyActive <= 1'b0;
        else cpPtr <= cpPtr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.wrData) spad[wrIdx] <= rxData;
    else if (stb.rmStep && !memPtr[ADDR_W]) spad[memPtr[OFF_W-1:0]] <= mem[memPtr[ADDR_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (copyActive) mem[{ta[ADDR_W-1:OFF_W], cpPtr}] <= spad[cpPtr];
  end

  always_comb begin
    unique case (stb.txSel)
      TX_TA1:  txData = st.ta1Byte;
      TX_TA2:  txData = st.ta2Byte;
      TX_ES:   txData = st.esByte;
      TX_SPAD: txData = rdPtr[OFF_W] ? 8'hFF : spad[rdPtr[OFF_W-1:0]];
      TX_CRCL: txData = ~crc[7:0];
      TX_CRCH: txData = ~crc[15:8];
      TX_MEM:  txData = memPtr[ADDR_W] ? 8'hFF : mem[memPtr[ADDR_W-1:0]];
      TX_ALT:  txData = 8'hAA;
      default: txData = 8'hFF;
    endcase
  end

  // R3: PF only rises on a partial byte or a power-loss pulse
  assert_pf_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf) |-> $past(stb.setPf || powerLoss));

  // R7: the array copy has finished before busy drops
  assert_copy_within_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb.busy) |-> !copyActive);

  // R6: a commit never starts on invalid staged data
  assert_commit_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.copyStart |-> !pf);
endmodule

// File: rtl/spad_mem_ctrl.sv
module spad_mem_ctrl
  import spadmem_pkg::*;
#(
  parameter int PAGES = 16,
  parameter int PROG_CYCLES = 40  // must be at least SPAD_BYTES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busReset,
  input  logic       powerLoss,
  input  logic       rxValid,
  input  logic [7:0] rxData,
  input  logic       rxPartial,
  input  logic       txReq,
  output logic [7:0] txData,
  output logic       busy
);
  strobe_t stb;
  status_t st;

  spadmem_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busReset(busReset), .rxValid(rxValid),
    .rxData(rxData), .rxPartial(rxPartial), .txReq(txReq), .st(st), .stb(stb)
  );

  spadmem_dpath #(.PAGES(PAGES)) u_dpath (
    .clk(clk), .rst_n(rst_n), .powerLoss(powerLoss), .rxData(rxData),
    .stb(stb), .st(st), .txData(txData)
  );

  assign busy = stb.busy;
endmodule

// File: tb/tb_spad_mem_ctrl.sv
module tb_spad_mem_ctrl;
  localparam int PROG = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busReset = 1'b0, powerLoss = 1'b0, rxValid = 1'b0, rxPartial = 1'b0, txReq = 1'b0;
  logic [7:0] rxData = 8'h00;
  logic [7:0] txData;
  logic busy;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [7:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  spad_mem_ctrl #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .busReset(busReset), .powerLoss(powerLoss),
    .rxValid(rxValid), .rxData(rxData), .rxPartial(rxPartial), .txReq(txReq),
    .txData(txData), .busy(busy)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic expectRd(input logic [7:0] b, input string tag);
    expQ.push_back(b); tagQ.push_back(tag);
    txReq = 1'b1;
    @(negedge clk);
    txReq = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  // Scoreboard monitor: compares each offered byte as the bench takes it
  initial forever begin
    @(negedge clk);
    #1;
    if (txReq) begin
      if (expQ.size() == 0) chk("monitor underflow", txData, 8'hxx);
      else chk(tagQ.pop_front(), txData, expQ.pop_front());
    end
  end

  function automatic logic [15:0] refCrc(input logic [7:0] bytes[]);
    logic [15:0] c = 16'h0000;
    foreach (bytes[k])
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = c[0] ^ bytes[k][j];
        c = {1'b0, c[15:1]};
        if (fb) c = c ^ 16'hA001;
      end
    return c;
  endfunction

  initial begin
    #800000;
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!finished) $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [15:0] crcExp;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 txData idle", txData, 8'hFF);
    chk("R12 busy idle", {7'b0, busy}, 8'h00);
    sendByte(8'hAA);
    expectRd(8'h00, "R12 TA1"); expectRd(8'h00, "R12 TA2"); expectRd(8'h20, "R12 ES");
    pulse(busReset);

    // R1 short write in mid-buffer, R10 abort keeps data
    sendByte(8'h0F); sendByte(8'h43); sendByte(8'h00);
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h33);
    pulse(busReset);
    sendByte(8'hAA);
    expectRd(8'h43, "R1 TA1"); expectRd(8'h00, "R1 TA2"); expectRd(8'h05, "R1 ES");
    expectRd(8'h11, "R1 d0"); expectRd(8'h22, "R1 d1"); expectRd(8'h33, "R1 d2");
    pulse(busReset);

    // R6/R7 accepted commit, byte during busy ignored
    sendByte(8'h55); sendByte(8'h43); sendByte(8'h00); sendByte(8'h05);
    chk("R7 busy starts", {7'b0, busy}, 8'h01);
    sendByte(8'h99);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk("R7 busy length", 8'(n), 8'(PROG - 1));
    expectRd(8'hAA, "R7 done pattern"); expectRd(8'hAA, "R7 done pattern repeat");
    pulse(busReset);
    sendByte(8'hAA);
    expectRd(8'h43, "R6 TA1"); expectRd(8'h00, "R6 TA2"); expectRd(8'h85, "R6 AA set");
    pulse(busReset);
    sendByte(8'hF0); sendByte(8'h43); sendByte(8'h00);
    expectRd(8'h11, "R8 array 43"); expectRd(8'h22, "R8 array 44"); expectRd(8'h33, "R8 array 45");
    pulse(busReset);

    // R2/R4/R5 write to buffer end from an out-of-range address
    sendByte(8'h0F); sendByte(8'hFD); sendByte(8'hFF);
    sendByte(8'hA1); sendByte(8'hB2); sendByte(8'hC3);
    crcExp = ~refCrc('{8'h0F, 8'hFD, 8'hFF, 8'hA1, 8'hB2, 8'hC3});
    expectRd(crcExp[7:0], "R4 CRC low"); expectRd(crcExp[15:8], "R4 CRC high");
    expectRd(8'hFF, "R4 after CRC");
    pulse(busReset);
    sendByte(8'hAA);
    expectRd(8'hFD, "R5 TA1"); expectRd(8'h01, "R2 TA2 masked"); expectRd(8'h1F, "R5 ES");
    expectRd(8'hA1, "R5 d29"); expectRd(8'hB2, "R5 d30"); expectRd(8'hC3, "R5 d31");
    expectRd(8'hFF, "R5 past end"); expectRd(8'hFF, "R5 past end 2");
    pulse(busReset);
    sendByte(8'h55); sendByte(8'hFD); sendByte(8'h01); sendByte(8'h1F);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    expectRd(8'hAA, "R7 second commit");
    pulse(busReset);
    sendByte(8'hF0); sendByte(8'hFE); sendByte(8'hFF);
    expectRd(8'hB2, "R8 array 1FE"); expectRd(8'hC3, "R8 array 1FF");
    expectRd(8'hFF, "R8 past end"); expectRd(8'hFF, "R8 past end 2");
    pulse(busReset);

    // R9 read-array refills buffer and replaces target address
    sendByte(8'h0F); sendByte(8'h23); sendByte(8'h00); sendByte(8'h77);
    pulse(busReset);
    sendByte(8'hF0); sendByte(8'h43); sendByte(8'h00);
    expectRd(8'h11, "R9 array byte");
    pulse(busReset);
    sendByte(8'hAA);
    expectRd(8'h43, "R8 TA replaced"); expectRd(8'h00, "R8 TA2"); expectRd(8'h03, "R8 E kept");
    expectRd(8'h11, "R9 buffer refilled");
    pulse(busReset);

    // R3 partial byte, R6 refusal with PF set
    sendByte(8'h0F); sendByte(8'h10); sendByte(8'h00); sendByte(8'h5A);
    pulse(rxPartial);
    pulse(busReset);
    sendByte(8'hAA);
    expectRd(8'h10, "R3 TA1"); expectRd(8'h00, "R3 TA2"); expectRd(8'h30, "R3 PF set");
    expectRd(8'h5A, "R3 full byte kept");
    pulse(busReset);
    sendByte(8'h55); sendByte(8'h10); sendByte(8'h00); sendByte(8'h30);
    chk("R6 no busy with PF", {7'b0, busy}, 8'h00);
    expectRd(8'hFF, "R6 refused PF");
    pulse(busReset);

    // R6 mismatched echo
    sendByte(8'h0F); sendByte(8'h10); sendByte(8'h00); sendByte(8'h5A);
    pulse(busReset);
    sendByte(8'h55); sendByte(8'h10); sendByte(8'h00); sendByte(8'h11);
    chk("R6 no busy on mismatch", {7'b0, busy}, 8'h00);
    expectRd(8'hFF, "R6 mismatch ones"); expectRd(8'hFF, "R6 mismatch ones 2");
    pulse(busReset);
    sendByte(8'hAA);
    expectRd(8'h10, "R6 TA1"); expectRd(8'h00, "R6 TA2"); expectRd(8'h10, "R6 AA still clear");
    pulse(busReset);

    // R3 power loss
    pulse(powerLoss);
    sendByte(8'hAA);
    expectRd(8'h10, "R3 TA1 kept"); expectRd(8'h00, "R3 TA2 kept"); expectRd(8'h30, "R3 power loss PF");
    pulse(busReset);

    // R11 unknown command
    sendByte(8'h3C);
    expectRd(8'hFF, "R11 unknown");
    sendByte(8'h0F);
    expectRd(8'hFF, "R11 ignores bytes");
    pulse(busReset);

    // R10 abort mid-command then new command accepted
    sendByte(8'h0F); sendByte(8'h44);
    pulse(busReset);
    sendByte(8'hAA);
    expectRd(8'h44, "R10 TA1"); expectRd(8'h00, "R10 TA2"); expectRd(8'h04, "R10 ES");
    pulse(busReset);

    repeat (2) @(negedge clk);
    testsRun++;
    if (expQ.size() != 0) begin
      testsFailed++;
      $display("FAIL scoreboard: got %0d pending expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule